// File: doc/BRIEF.md
# Stream Vector Execution Sequencer

This block is the integer arithmetic core of a stream vector unit. It keeps four small local stream registers, each of eight 64-bit words, and those registers are the only operand source for its two 64-bit integer lanes. A single three-operand instruction names two source registers, one destination register, an opcode and an element count. The block then applies that one operation element by element, eight or sixteen times, without any further control from outside.

Each local register is split into four banks that each hold a pair of adjacent words. This lets both lanes read their operands in the same cycle: lane 0 takes element 2i and lane 1 takes element 2i+1. An eight-element instruction therefore issues over four cycles, and a sixteen-element instruction issues over eight. Each lane has two register stages. Results are written back into the destination bank, and a one-cycle completion pulse follows the last writeback.

The local registers are filled from the stream register file over a 256-bit path, half a register per cycle. A combinational read port returns any single word so that results can be drained.

Top module: `svx_exec_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are low and every word of every local register reads zero.
- R2: A load request with `load_valid` high and `busy` low writes four words into register `load_reg`. Word k (0..3) is taken from `load_data[64k+63:64k]` and goes to word 4*`load_half`+k. A load request made while `busy` is high changes no register.
- R3: Opcode encodings, all modulo 2^64: 0 gives a+b, 1 gives a−b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, and 5 gives a shifted left by b[5:0]. Opcodes 6 and 7 copy a.
- R4: When `rep16` is 0, the instruction writes op(A[w], B[w]) to word w of register `dst` for w = 0..7, where A is register `src_a` and B is register `src_b`. No other register changes.
- R5: When `rep16` is 1, element e (0..15) reads word e mod 8 of registers (`src_a`+e/8) mod 4 and (`src_b`+e/8) mod 4. It writes word e mod 8 of register (`dst`+e/8) mod 4. The effect equals processing the elements in ascending order, so element e+8 sees a word that element e wrote earlier in the same instruction.
- R6: `done` is high for exactly one cycle. It rises at the rising edge that comes P+2 edges after the edge that accepted `start`, where P is 4 when `rep16` is 0 and 8 when it is 1.
- R7: `busy` is high from the accepting edge until the edge on which `done` rises. A `start` seen while `busy` is high is ignored: it causes no register change and no extra `done`.
- R8: A load and a `start` that are both accepted at the same edge both take effect, and the instruction operates on the freshly loaded words.
- R9: `rd_data` returns word `rd_idx` of register `rd_reg` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Load request for one half of a local register |
| load_reg | input | 2 | Local register to load |
| load_half | input | 1 | 0 selects words 0-3, 1 selects words 4-7 |
| load_data | input | 256 | Four 64-bit words, word 0 in the low bits |
| start | input | 1 | Instruction request, taken when idle |
| opcode | input | 3 | Integer operation select |
| rep16 | input | 1 | 0 gives 8 elements, 1 gives 16 elements |
| src_a | input | 2 | First source register |
| src_b | input | 2 | Second source register |
| dst | input | 2 | Destination register |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_reg | input | 2 | Read-out register select |
| rd_idx | input | 3 | Read-out word select |
| rd_data | output | 64 | Selected word |

## Verification
Two of the block's functions can fall in the same cycle.

The first pair is a load and an instruction start. The bench raises `load_valid` and `start` on the same edge, with the loaded register also serving as a source. It then compares the result with a model that applies the load before the operation. The bench also injects a load and a second `start` partway through an instruction, then confirms that the model with the injection discarded still matches every word and that only one `done` appears.

The second pair is a writeback and an operand read in sixteen-element mode. The bench makes the destination equal to the register that the upper eight elements read. The sequential element-order model is then the judge of whether early writebacks and later reads were ordered correctly.

// File: rtl/svx_pkg.sv
// Package: shared operation codes for the stream vector execution core.
// Assumes a 3-bit opcode field; codes 6 and 7 both act as a copy of operand a.
package svx_pkg;
    typedef enum logic [2:0] {
        SVX_ADD  = 3'd0,
        SVX_SUB  = 3'd1,
        SVX_AND  = 3'd2,
        SVX_OR   = 3'd3,
        SVX_XOR  = 3'd4,
        SVX_SHL  = 3'd5,
        SVX_CPY6 = 3'd6,
        SVX_CPY7 = 3'd7
    } svx_op_e;
endpackage

// File: rtl/svx_lreg_bank.sv
// Local stream register storage. Each of NREG registers holds WORDS words,
// stored as WORDS/LANES banks of LANES adjacent words so that all lanes read
// one bank per cycle. Assumes LANES divides the number of words per load beat
// and that NREG, WORDS and LANES are powers of two.
module svx_lreg_bank #(
    parameter int DW     = 64,
    parameter int NREG   = 4,
    parameter int WORDS  = 8,
    parameter int LANES  = 2,
    parameter int LOAD_W = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_en,
    input  logic [$clog2(NREG)-1:0]    ld_reg,
    input  logic [$clog2(WORDS*DW/LOAD_W)-1:0] ld_beat,
    input  logic [LOAD_W-1:0]          ld_data,
    input  logic                       wb_en,
    input  logic [$clog2(NREG)-1:0]    wb_reg,
    input  logic [$clog2(WORDS/LANES)-1:0] wb_bank,
    input  logic [LANES*DW-1:0]        wb_data,
    input  logic [$clog2(NREG)-1:0]    ra_reg,
    input  logic [$clog2(NREG)-1:0]    rb_reg,
    input  logic [$clog2(WORDS/LANES)-1:0] r_bank,
    output logic [LANES*DW-1:0]        ra_data,
    output logic [LANES*DW-1:0]        rb_data,
    input  logic [$clog2(NREG)-1:0]    rd_reg,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [DW-1:0]              rd_data
);
    localparam int BANKS      = WORDS / LANES;
    localparam int LOAD_WORDS = LOAD_W / DW;
    localparam int LBW        = $clog2(WORDS / LOAD_WORDS);
    localparam int IW         = $clog2(WORDS);
    localparam int LW         = $clog2(LANES);

    logic [LANES*DW-1:0] bank_q [NREG][BANKS];
    logic [LANES*DW-1:0] rd_pair;

    for (genvar g_r = 0; g_r < NREG; g_r++) begin : g_reg
        for (genvar g_b = 0; g_b < BANKS; g_b++) begin : g_bank
            localparam int BEAT = (g_b * LANES) / LOAD_WORDS;
            localparam int OFS  = (g_b * LANES) % LOAD_WORDS;
            logic [LANES*DW-1:0] q;

            // Bank update: lane writeback has priority over a load beat.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wb_en && wb_reg == g_r[$clog2(NREG)-1:0] &&
                             wb_bank == g_b[$clog2(BANKS)-1:0]) begin
                    q <= wb_data;
                end else if (ld_en && ld_reg == g_r[$clog2(NREG)-1:0] &&
                             ld_beat == BEAT[LBW-1:0]) begin
                    q <= ld_data[OFS*DW +: LANES*DW];
                end
            end

            assign bank_q[g_r][g_b] = q;
        end
    end

    // Operand pair read for both lanes from the bank being issued.
    always_comb begin
        ra_data = bank_q[ra_reg][r_bank];
        rb_data = bank_q[rb_reg][r_bank];
    end

    // Single-word read-out path.
    always_comb begin
        rd_pair = bank_q[rd_reg][rd_idx[IW-1:LW]];
        rd_data = rd_pair[rd_idx[LW-1:0]*DW +: DW];
    end
endmodule

// File: rtl/svx_seq.sv
// Element sequencer. Latches one instruction on start_ok and walks the bank
// index, one bank pair per cycle, over one register (8 elements) or two
// consecutive registers (16 elements). Assumes NREG is a power of two so the
// register index wraps naturally.
module svx_seq #(
    parameter int NREG  = 4,
    parameter int BANKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_ok,
    input  logic                      rep16_in,
    input  logic [2:0]                op_in,
    input  logic [$clog2(NREG)-1:0]   a_in,
    input  logic [$clog2(NREG)-1:0]   b_in,
    input  logic [$clog2(NREG)-1:0]   d_in,
    output logic                      issuing,
    output logic [$clog2(BANKS)-1:0]  iss_bank,
    output logic [$clog2(NREG)-1:0]   iss_ra,
    output logic [$clog2(NREG)-1:0]   iss_rb,
    output logic [$clog2(NREG)-1:0]   iss_rd,
    output logic [2:0]                iss_op,
    output logic                      iss_last
);
    localparam int RW = $clog2(NREG);
    localparam int BW = $clog2(BANKS);
    localparam int CW = BW + 1;
    localparam logic [CW-1:0] LAST8  = CW'(BANKS - 1);
    localparam logic [CW-1:0] LAST16 = CW'(2 * BANKS - 1);

    logic [CW-1:0] cnt;
    logic          rep16_q;
    logic [RW-1:0] a_q, b_q, d_q;
    logic [2:0]    op_q;
    logic [RW-1:0] hi;

    // Instruction latch and element-pair counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            cnt     <= '0;
            rep16_q <= 1'b0;
            a_q     <= '0;
            b_q     <= '0;
            d_q     <= '0;
            op_q    <= '0;
        end else if (start_ok) begin
            issuing <= 1'b1;
            cnt     <= '0;
            rep16_q <= rep16_in;
            a_q     <= a_in;
            b_q     <= b_in;
            d_q     <= d_in;
            op_q    <= op_in;
        end else if (issuing) begin
            if (iss_last) issuing <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    // Issue fields: upper count bit steps to the next register in 16-element mode.
    always_comb begin
        hi       = RW'(cnt[BW]);
        iss_bank = cnt[BW-1:0];
        iss_ra   = a_q + hi;
        iss_rb   = b_q + hi;
        iss_rd   = d_q + hi;
        iss_op   = op_q;
        iss_last = issuing && (cnt == (rep16_q ? LAST16 : LAST8));
    end
endmodule

// File: rtl/svx_int_lane.sv
// One fully pipelined integer lane: stage 1 registers operands and opcode,
// stage 2 registers the result. Assumes DW is a power of two for the shift.
module svx_int_lane
    import svx_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [2:0]    in_op,
    output logic [DW-1:0] res
);
    localparam int SHW = $clog2(DW);

    logic [DW-1:0] s1_a, s1_b, alu;
    svx_op_e       s1_op;

    // Stage 1: operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_a  <= '0;
            s1_b  <= '0;
            s1_op <= SVX_ADD;
        end else begin
            s1_a  <= in_a;
            s1_b  <= in_b;
            s1_op <= svx_op_e'(in_op);
        end
    end

    // Operation select.
    always_comb begin
        case (s1_op)
            SVX_ADD: alu = s1_a + s1_b;
            SVX_SUB: alu = s1_a - s1_b;
            SVX_AND: alu = s1_a & s1_b;
            SVX_OR:  alu = s1_a | s1_b;
            SVX_XOR: alu = s1_a ^ s1_b;
            SVX_SHL: alu = s1_a << s1_b[SHW-1:0];
            default: alu = s1_a;
        endcase
    end

    // Stage 2: result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) res <= '0;
        else        res <= alu;
    end
endmodule

// File: rtl/svx_exec_core.sv
// Stream vector execution core. Local registers feed LANES integer lanes; the
// sequencer issues one bank pair per cycle, a control pipeline matching the
// lanes' two stages carries the writeback target, and done pulses one cycle
// after the last writeback. Loads are accepted only while idle.
module svx_exec_core #(
    parameter int DW     = 64,
    parameter int NREG   = 4,
    parameter int WORDS  = 8,
    parameter int LANES  = 2,
    parameter int LOAD_W = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_valid,
    input  logic [$clog2(NREG)-1:0]           load_reg,
    input  logic [$clog2(WORDS*DW/LOAD_W)-1:0] load_half,
    input  logic [LOAD_W-1:0]                 load_data,
    input  logic                              start,
    input  logic [2:0]                        opcode,
    input  logic                              rep16,
    input  logic [$clog2(NREG)-1:0]           src_a,
    input  logic [$clog2(NREG)-1:0]           src_b,
    input  logic [$clog2(NREG)-1:0]           dst,
    output logic                              busy,
    output logic                              done,
    input  logic [$clog2(NREG)-1:0]           rd_reg,
    input  logic [$clog2(WORDS)-1:0]          rd_idx,
    output logic [DW-1:0]                     rd_data
);
    localparam int BANKS = WORDS / LANES;
    localparam int RW    = $clog2(NREG);
    localparam int BW    = $clog2(BANKS);

    logic                 start_ok, ld_ok;
    logic                 issuing, iss_last;
    logic [BW-1:0]        iss_bank;
    logic [RW-1:0]        iss_ra, iss_rb, iss_rd;
    logic [2:0]           iss_op;
    logic [LANES*DW-1:0]  ra_data, rb_data, wb_data;
    logic                 p1_v, p2_v, p1_last, p2_last;
    logic [RW-1:0]        p1_reg, p2_reg;
    logic [BW-1:0]        p1_bank, p2_bank;

    assign busy     = issuing | p1_v | p2_v;
    assign start_ok = start & ~busy;
    assign ld_ok    = load_valid & ~busy;

    svx_seq #(.NREG(NREG), .BANKS(BANKS)) i_seq (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .rep16_in(rep16),
        .op_in(opcode), .a_in(src_a), .b_in(src_b), .d_in(dst),
        .issuing(issuing), .iss_bank(iss_bank), .iss_ra(iss_ra),
        .iss_rb(iss_rb), .iss_rd(iss_rd), .iss_op(iss_op), .iss_last(iss_last)
    );

    svx_lreg_bank #(.DW(DW), .NREG(NREG), .WORDS(WORDS), .LANES(LANES),
                    .LOAD_W(LOAD_W)) i_lreg (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_ok), .ld_reg(load_reg), .ld_beat(load_half), .ld_data(load_data),
        .wb_en(p2_v), .wb_reg(p2_reg), .wb_bank(p2_bank), .wb_data(wb_data),
        .ra_reg(iss_ra), .rb_reg(iss_rb), .r_bank(iss_bank),
        .ra_data(ra_data), .rb_data(rb_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    for (genvar g_l = 0; g_l < LANES; g_l++) begin : g_lane
        svx_int_lane #(.DW(DW)) i_lane (
            .clk(clk), .rst_n(rst_n),
            .in_a(ra_data[g_l*DW +: DW]), .in_b(rb_data[g_l*DW +: DW]),
            .in_op(iss_op), .res(wb_data[g_l*DW +: DW])
        );
    end

    // Control pipeline aligned with the lanes' two stages, plus completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0; p1_last <= 1'b0; p1_reg <= '0; p1_bank <= '0;
            p2_v <= 1'b0; p2_last <= 1'b0; p2_reg <= '0; p2_bank <= '0;
            done <= 1'b0;
        end else begin
            p1_v    <= issuing;
            p1_last <= iss_last;
            p1_reg  <= iss_rd;
            p1_bank <= iss_bank;
            p2_v    <= p1_v;
            p2_last <= p1_last;
            p2_reg  <= p1_reg;
            p2_bank <= p1_bank;
            done    <= p2_v & p2_last;
        end
    end
endmodule

// File: rtl/svx_exec_chk.sv
// Property checker for svx_exec_core: completion timing and busy handshake.
// Tracks the cycles since an accepted start with a counter, so no delay depends
// on a parameter.
module svx_exec_chk #(
    parameter int PAIRS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rep16,
    input logic busy,
    input logic done
);
    logic       track;
    logic [7:0] age, want;

    // Age counter started by each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track <= 1'b0;
            age   <= '0;
            want  <= '0;
        end else if (start && !busy) begin
            track <= 1'b1;
            age   <= 8'd1;
            want  <= 8'(rep16 ? 2 * PAIRS : PAIRS) + 8'd3;
        end else if (track) begin
            age <= age + 8'd1;
            if (done) track <= 1'b0;
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (track && age == want));

    // R7
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind svx_exec_core svx_exec_chk #(.PAIRS(WORDS / LANES)) i_svx_exec_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rep16(rep16),
    .busy(busy), .done(done)
);

// File: tb/test_svx_exec_core.sv
module test_svx_exec_core;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [1:0]   load_reg = '0;
    logic [0:0]   load_half = '0;
    logic [255:0] load_data = '0;
    logic         start = 1'b0;
    logic [2:0]   opcode = '0;
    logic         rep16 = 1'b0;
    logic [1:0]   src_a = '0, src_b = '0, dst = '0;
    logic         busy, done;
    logic [1:0]   rd_reg = '0;
    logic [2:0]   rd_idx = '0;
    logic [63:0]  rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] m [4][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    svx_exec_core i_svx_exec_core (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_reg(load_reg),
        .load_half(load_half), .load_data(load_data), .start(start),
        .opcode(opcode), .rep16(rep16), .src_a(src_a), .src_b(src_b), .dst(dst),
        .busy(busy), .done(done), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [63:0] f_op(int op, logic [63:0] a, logic [63:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[5:0];
            default: return a;
        endcase
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic model_load(int r, int h, logic [255:0] d);
        for (int k = 0; k < 4; k++) m[r][h*4+k] = d[64*k +: 64];
    endtask

    task automatic model_run(int op, int sa, int sb, int d, bit r16);
        for (int e = 0; e < (r16 ? 16 : 8); e++)
            m[(d + e/8) % 4][e % 8] =
                f_op(op, m[(sa + e/8) % 4][e % 8], m[(sb + e/8) % 4][e % 8]);
    endtask

    task automatic check_regs(string tag);
        for (int r = 0; r < 4; r++)
            for (int w = 0; w < 8; w++) begin
                rd_reg = 2'(r);
                rd_idx = 3'(w);
                #1;
                chk(rd_data === m[r][w], tag, rd_data, m[r][w]);
            end
    endtask

    // R2: load one half register while idle
    task automatic do_load(int r, int h, logic [255:0] d);
        @(negedge clk);
        load_valid = 1'b1;
        load_reg = 2'(r);
        load_half = 1'(h);
        load_data = d;
        @(negedge clk);
        load_valid = 1'b0;
        model_load(r, h, d);
    endtask

    // Run one instruction; optional co-load (R8) and injections while busy (R7, R2)
    task automatic run(int op, int sa, int sb, int d, bit r16,
                       bit co_load, bit inj_start, bit inj_load, string tag);
        int k;
        logic [255:0] cd;
        cd = rnd256();
        @(negedge clk);
        start = 1'b1;
        opcode = 3'(op);
        src_a = 2'(sa);
        src_b = 2'(sb);
        dst = 2'(d);
        rep16 = r16;
        if (co_load) begin
            load_valid = 1'b1;
            load_reg = 2'(sa);
            load_half = 1'b1;
            load_data = cd;
            model_load(sa, 1, cd);
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        load_valid = 1'b0;
        k = 0;
        while (1) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (done || k > 40) break;
            if (k == 2) begin
                chk(busy === 1'b1, {tag, " R7 busy mid-run"}, 64'(busy), 64'd1);
                if (inj_start) begin
                    start = 1'b1;
                    dst = 2'(d + 1);
                    opcode = 3'(op ^ 1);
                end
                if (inj_load) begin
                    load_valid = 1'b1;
                    load_reg = 2'(sa);
                    load_half = 1'b0;
                    load_data = rnd256();
                end
            end else if (k == 3) begin
                start = 1'b0;
                load_valid = 1'b0;
            end
        end
        start = 1'b0;
        load_valid = 1'b0;
        chk(k == (r16 ? 10 : 6), {tag, " R6 done latency"}, 64'(k), r16 ? 64'd10 : 64'd6);
        chk(busy === 1'b0, {tag, " R7 idle at done"}, 64'(busy), 64'd0);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R6 single pulse"}, 64'(done), 64'd0);
        if (inj_start) begin
            repeat (12) begin
                @(negedge clk);
                chk(done === 1'b0, {tag, " R7 no extra done"}, 64'(done), 64'd0);
            end
        end
        model_run(op, sa, sb, d, r16);
        check_regs({tag, " regs"});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd5150));
        for (int r = 0; r < 4; r++)
            for (int w = 0; w < 8; w++) m[r][w] = '0;

        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R9: all words zero after reset
        check_regs("R1 R9 reset contents");

        // R2: fill every register, both halves
        for (int r = 0; r < 4; r++)
            for (int h = 0; h < 2; h++) do_load(r, h, rnd256());
        check_regs("R2 loads");

        // R3, R4: each opcode in 8-element mode
        for (int op = 0; op < 8; op++)
            run(op, op % 4, (op + 1) % 4, (op + 2) % 4, 1'b0, 0, 0, 0, "R3 R4 opcode");

        // R3: shift boundaries, amount 63 and amount with upper bits set
        do_load(1, 0, {64'hFFFF_FFFF_FFFF_FF00 | 64'd63, 64'h40, 64'd1, 64'd0});
        do_load(1, 1, {64'h8000_0000_0000_0000, 64'd64, 64'd65, 64'd127});
        do_load(0, 0, {64'd1, 64'hDEAD_BEEF, 64'd3, 64'd1});
        do_load(0, 1, {64'd5, 64'd7, 64'd9, 64'h1});
        run(5, 0, 1, 2, 1'b0, 0, 0, 0, "R3 shift boundary");

        // R5: 16-element, destination overlaps the register read by the upper half
        run(0, 1, 2, 2, 1'b1, 0, 0, 0, "R5 overlap");
        // R5: 16-element with register index wrap
        run(4, 3, 3, 3, 1'b1, 0, 0, 0, "R5 wrap");

        // R7: start during busy ignored
        run(1, 0, 1, 2, 1'b0, 0, 1, 0, "R7 start while busy");
        // R2: load during busy ignored
        run(2, 3, 0, 1, 1'b1, 0, 0, 1, "R2 load while busy");
        // R8: load together with start, loaded register is a source
        run(0, 2, 3, 0, 1'b0, 1, 0, 0, "R8 co-load");
        run(3, 1, 2, 1, 1'b1, 1, 0, 0, "R8 co-load 16");

        // Random mix of loads and instructions
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 3 == 0)
                do_load($urandom % 4, $urandom % 2, rnd256());
            else
                run($urandom % 8, $urandom % 4, $urandom % 4, $urandom % 4,
                    1'($urandom % 2), 1'($urandom % 4 == 0), 1'($urandom % 5 == 0),
                    1'($urandom % 5 == 0), "R3 R4 R5 random");
        end

        summary();
    end
endmodule